// File: doc/BRIEF.md
# I2C Interrupt Status Unit

This block collects the interrupt conditions of a two-wire serial bus controller into one 12-bit raw status vector, and it keeps a separate 16-bit register that records why a transmit was abandoned. Two kinds of input feed it. Single-cycle event pulses come from the FIFOs, the master and slave state machines and the bus monitor. Level information comes from the FIFO fill counts and their programmed thresholds.

Software-facing logic elsewhere clears bits with a one-cycle strobe that carries a 12-bit mask. The same logic supplies a 12-bit enable mask, from which the block builds the masked status and a single combined interrupt line. The block also reports whether either protocol state machine is busy. Some status bits are sticky and some follow a level, so the way a bit leaves the set state depends on its kind: an explicit clear, a disable of the controller, or both state machines reaching idle while the controller is disabled.

Every raw status bit and every cause bit is a register. It takes its new value on the clock edge that samples its inputs. The masked status and the combined interrupt are combinational from the raw register and the enable mask.

Top module: `i2c_irq_status`

## Requirements
- R1: The raw status bit positions are fixed. Bit 0 is RX underflow, bit 1 is RX overflow and bit 2 is RX at threshold. Bit 3 is TX overflow, bit 4 is TX at threshold and bit 5 is read request. Bit 6 is transmit abort, bit 7 is RX done and bit 8 is bus activity. Bit 9 is stop seen, bit 10 is start or restart seen and bit 11 is general call. Each event pulse sets only its own bit, and bit 6 is set whenever any abort-cause bit is set.
- R2: Bit 2 is 1 while the controller is enabled and the RX fill level is greater than or equal to the RX threshold. It is 0 when the level is below the threshold, and it is always 0 while the controller is disabled.
- R3: While the controller is enabled, bit 4 is 1 when the TX fill level is less than or equal to the TX threshold. While the controller is disabled, bit 4 is 1 only while the master or slave FSM is active.
- R4: An event bit stays set until a clear strobe carries a mask with a 1 at that bit's position. A clear whose mask has a 0 at that position has no effect on the bit.
- R5: While the controller is disabled, bits 0, 1 and 3 keep their value as long as either FSM is active. They clear once both FSMs are idle.
- R6: Bit 8 stays set after the bus and both FSMs go idle, and it leaves the set state only through an explicit clear.
- R7: A clear strobe whose mask has bit 6 set, including the all-ones mask 0xFFF, zeroes all 16 abort-cause bits. A clear without bit 6 leaves them unchanged.
- R8: A cause pulse on bit 14 (slave lost arbitration) sets cause bits 14 and 12 on the same edge.
- R9: If the START-byte no-restart condition is still true when cause bit 9 is cleared, bit 9 reads 0 for one cycle and then is set again.
- R10: Bit 11 is set only by a received and acknowledged general-call pulse. It clears when the controller is disabled or when it is explicitly cleared.
- R11: An event arriving in the same cycle as a clear of its bit wins, and the bit stays set.
- R12: The masked status equals the raw status ANDed with the enable mask. The combined interrupt is 1 exactly when the masked status is nonzero.
- R13: The busy output is 1 while the master FSM or the slave FSM is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enabled |
| mst_active | input | 1 | Master FSM not idle |
| slv_active | input | 1 | Slave FSM not idle |
| rx_under_ev | input | 1 | Pulse: read of an empty RX FIFO |
| rx_over_ev | input | 1 | Pulse: byte dropped on a full RX FIFO |
| tx_over_ev | input | 1 | Pulse: command pushed into a full TX FIFO |
| rd_req_ev | input | 1 | Pulse: remote master requests data |
| rx_done_ev | input | 1 | Pulse: slave-transmit byte not acknowledged |
| bus_act_ev | input | 1 | Pulse: activity seen on the bus |
| stop_ev | input | 1 | Pulse: stop condition seen |
| start_ev | input | 1 | Pulse: start or restart seen |
| gcall_ev | input | 1 | Pulse: general call received and acknowledged |
| abort_ev | input | 16 | Per-cause transmit-abort pulses |
| sbyte_norst_cond | input | 1 | START-byte no-restart condition still present |
| rx_level | input | LW | RX FIFO fill level |
| rx_thresh | input | LW | RX threshold |
| tx_level | input | LW | TX FIFO fill level |
| tx_thresh | input | LW | TX threshold |
| clr_stb | input | 1 | Single-cycle clear strobe |
| clr_mask | input | 12 | Bits to clear with the strobe |
| irq_en | input | 12 | Interrupt enable mask |
| raw_stat | output | 12 | Raw status vector |
| masked_stat | output | 12 | Raw status ANDed with the enable mask |
| irq | output | 1 | Combined interrupt |
| abort_cause | output | 16 | Transmit-abort cause register |
| busy | output | 1 | Either FSM active |

## Verification
The assertions check the following on every cycle:
- a pulse always sets its bit, even against a clear;
- the idle and disable rules for the sticky bits;
- the activity bit holds until it is explicitly cleared;
- a TX-abort clear empties the cause register;
- a slave arbitration loss sets two cause bits together;
- the drop-then-return sequence of cause bit 9;
- the forced-zero states of the two threshold bits.

Only the directed scenarios can show other behaviour: the exact bit position of each condition, the threshold comparisons at their boundary values, that clears with unrelated mask bits have no effect, and the combinational masking onto the combined interrupt line.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int STAT_W  = 12;
    localparam int CAUSE_W = 16;

    // Raw status bit positions (software decodes these positions).
    localparam int ST_RX_UNDER = 0;
    localparam int ST_RX_OVER  = 1;
    localparam int ST_RX_THR   = 2;
    localparam int ST_TX_OVER  = 3;
    localparam int ST_TX_THR   = 4;
    localparam int ST_RD_REQ   = 5;
    localparam int ST_TX_ABORT = 6;
    localparam int ST_RX_DONE  = 7;
    localparam int ST_ACTIVITY = 8;
    localparam int ST_STOP     = 9;
    localparam int ST_START    = 10;
    localparam int ST_GCALL    = 11;

    // Cause bits with special update rules.
    localparam int AB_SBYTE_NORST = 9;
    localparam int AB_ARB_LOST    = 12;
    localparam int AB_SLV_ARB     = 14;

    // Bits held by an event flop; the other bits are derived elsewhere.
    localparam logic [STAT_W-1:0] EVT_BITS =
        STAT_W'((1 << ST_RX_UNDER) | (1 << ST_RX_OVER) | (1 << ST_TX_OVER) |
                (1 << ST_RD_REQ)   | (1 << ST_RX_DONE) | (1 << ST_ACTIVITY) |
                (1 << ST_STOP)     | (1 << ST_START)   | (1 << ST_GCALL));
    // Bits that clear when disabled and both FSMs are idle.
    localparam logic [STAT_W-1:0] IDLE_CLR_BITS =
        STAT_W'((1 << ST_RX_UNDER) | (1 << ST_RX_OVER) | (1 << ST_TX_OVER));
    // Bits that clear as soon as the controller is disabled.
    localparam logic [STAT_W-1:0] DIS_CLR_BITS = STAT_W'(1 << ST_GCALL);

    typedef struct packed {
        logic              stb;
        logic [STAT_W-1:0] mask;
    } clr_req_t;

    typedef struct packed {
        logic rx_under;
        logic rx_over;
        logic tx_over;
        logic rd_req;
        logic rx_done;
        logic bus_act;
        logic stop;
        logic start;
        logic gcall;
    } evt_in_t;

    function automatic logic [STAT_W-1:0] clr_vector(clr_req_t r);
        return r.stb ? r.mask : '0;
    endfunction

    function automatic logic [STAT_W-1:0] evt_vector(evt_in_t e);
        logic [STAT_W-1:0] v;
        v = '0;
        v[ST_RX_UNDER] = e.rx_under;
        v[ST_RX_OVER]  = e.rx_over;
        v[ST_TX_OVER]  = e.tx_over;
        v[ST_RD_REQ]   = e.rd_req;
        v[ST_RX_DONE]  = e.rx_done;
        v[ST_ACTIVITY] = e.bus_act;
        v[ST_STOP]     = e.stop;
        v[ST_START]    = e.start;
        v[ST_GCALL]    = e.gcall;
        return v;
    endfunction

    function automatic logic [CAUSE_W-1:0] cause_set(logic [CAUSE_W-1:0] ev, logic rearm9);
        logic [CAUSE_W-1:0] v;
        v = ev;
        v[AB_ARB_LOST]    = ev[AB_ARB_LOST] | ev[AB_SLV_ARB];
        v[AB_SBYTE_NORST] = ev[AB_SBYTE_NORST] | rearm9;
        return v;
    endfunction

endpackage

// File: rtl/i2c_irq_evbank.sv
module i2c_irq_evbank
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              fsm_busy,
    input  logic [STAT_W-1:0] evt,
    input  logic [STAT_W-1:0] clr,
    output logic [STAT_W-1:0] flag_q
);

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (EVT_BITS[i]) begin : g_flop
            logic bit_q;
            logic clr_hit;

            assign clr_hit = clr[i]
                           | (DIS_CLR_BITS[i]  & ~enable)
                           | (IDLE_CLR_BITS[i] & ~enable & ~fsm_busy);

            always_ff @(posedge clk) begin
                if (rst)          bit_q <= 1'b0;
                else if (evt[i])  bit_q <= 1'b1;
                else if (clr_hit) bit_q <= 1'b0;
            end

            assign flag_q[i] = bit_q;

            // R11: a pulse always lands, even against a clear
            a_r11_event_wins: assert property (@(posedge clk) disable iff (rst)
                evt[i] |=> bit_q);

            // R4: held while enabled and not addressed by a clear
            a_r4_hold: assert property (@(posedge clk) disable iff (rst)
                bit_q && enable && !clr[i] |=> bit_q);

            if (IDLE_CLR_BITS[i]) begin : g_idle_chk
                // R5: disabled and idle drops the bit
                a_r5_idle_clear: assert property (@(posedge clk) disable iff (rst)
                    !enable && !fsm_busy && !evt[i] |=> !bit_q);
                // R5: disabled but busy keeps the bit
                a_r5_busy_keep: assert property (@(posedge clk) disable iff (rst)
                    bit_q && !enable && fsm_busy && !clr[i] |=> bit_q);
            end

            if (DIS_CLR_BITS[i]) begin : g_dis_chk
                // R10: general call drops on disable
                a_r10_gcall_disable: assert property (@(posedge clk) disable iff (rst)
                    !enable && !evt[i] |=> !bit_q);
            end

            if (i == ST_ACTIVITY) begin : g_act_chk
                // R6: activity leaves only through an explicit clear
                a_r6_activity_hold: assert property (@(posedge clk) disable iff (rst)
                    bit_q && !clr[i] |=> bit_q);
            end
        end else begin : g_none
            assign flag_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/i2c_irq_levels.sv
module i2c_irq_levels #(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          fsm_busy,
    input  logic [LW-1:0] rx_lvl,
    input  logic [LW-1:0] rx_thr,
    input  logic [LW-1:0] tx_lvl,
    input  logic [LW-1:0] tx_thr,
    output logic          rx_thr_q,
    output logic          tx_thr_q
);

    logic rx_hit;
    logic tx_hit;

    assign rx_hit = rx_lvl >= rx_thr;
    assign tx_hit = tx_lvl <= tx_thr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_thr_q <= 1'b0;
            tx_thr_q <= 1'b0;
        end else begin
            rx_thr_q <= enable & rx_hit;
            tx_thr_q <= enable ? tx_hit : fsm_busy;
        end
    end

    // R2: RX threshold bit is forced low while disabled
    a_r2_rx_disabled: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !rx_thr_q);

    // R2: below threshold the bit drops
    a_r2_rx_below: assert property (@(posedge clk) disable iff (rst)
        rx_lvl < rx_thr |=> !rx_thr_q);

    // R3: disabled with idle FSMs reads 0
    a_r3_tx_idle: assert property (@(posedge clk) disable iff (rst)
        !enable && !fsm_busy |=> !tx_thr_q);

    // R3: disabled with an active FSM reads 1
    a_r3_tx_busy: assert property (@(posedge clk) disable iff (rst)
        !enable && fsm_busy |=> tx_thr_q);

endmodule

// File: rtl/i2c_irq_abort.sv
module i2c_irq_abort
    import i2c_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CAUSE_W-1:0] ab_evt,
    input  logic               sbyte_cond,
    input  logic               clr_all,
    output logic [CAUSE_W-1:0] cause_q
);

    logic               rearm_q;
    logic [CAUSE_W-1:0] set_vec;

    assign set_vec = cause_set(ab_evt, rearm_q & sbyte_cond);

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_cause
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)             bit_q <= 1'b0;
            else if (set_vec[i]) bit_q <= 1'b1;
            else if (clr_all)    bit_q <= 1'b0;
        end
        assign cause_q[i] = bit_q;
    end

    // Remembers a clear that removed bit 9 while its condition still held.
    always_ff @(posedge clk) begin
        if (rst) rearm_q <= 1'b0;
        else     rearm_q <= clr_all & cause_q[AB_SBYTE_NORST] & sbyte_cond
                          & ~set_vec[AB_SBYTE_NORST];
    end

    // R7: clearing the abort bit empties the cause register
    a_r7_cause_clear: assert property (@(posedge clk) disable iff (rst)
        clr_all && ab_evt == '0 && !rearm_q |=> cause_q == '0);

    // R8: slave arbitration loss also flags arbitration loss
    a_r8_slave_arb: assert property (@(posedge clk) disable iff (rst)
        ab_evt[AB_SLV_ARB] |=> cause_q[AB_SLV_ARB] && cause_q[AB_ARB_LOST]);

    // R9: bit 9 drops for one cycle, then returns if the condition held
    a_r9_rearm: assert property (@(posedge clk) disable iff (rst)
        clr_all && cause_q[AB_SBYTE_NORST] && sbyte_cond && !ab_evt[AB_SBYTE_NORST] && !rearm_q
        |=> !cause_q[AB_SBYTE_NORST] ##1 (cause_q[AB_SBYTE_NORST] || !$past(sbyte_cond)));

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
    import i2c_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               mst_active,
    input  logic               slv_active,
    input  logic               rx_under_ev,
    input  logic               rx_over_ev,
    input  logic               tx_over_ev,
    input  logic               rd_req_ev,
    input  logic               rx_done_ev,
    input  logic               bus_act_ev,
    input  logic               stop_ev,
    input  logic               start_ev,
    input  logic               gcall_ev,
    input  logic [CAUSE_W-1:0] abort_ev,
    input  logic               sbyte_norst_cond,
    input  logic [LW-1:0]      rx_level,
    input  logic [LW-1:0]      rx_thresh,
    input  logic [LW-1:0]      tx_level,
    input  logic [LW-1:0]      tx_thresh,
    input  logic               clr_stb,
    input  logic [STAT_W-1:0]  clr_mask,
    input  logic [STAT_W-1:0]  irq_en,
    output logic [STAT_W-1:0]  raw_stat,
    output logic [STAT_W-1:0]  masked_stat,
    output logic               irq,
    output logic [CAUSE_W-1:0] abort_cause,
    output logic               busy
);

    evt_in_t           evt_s;
    clr_req_t          clr_s;
    logic [STAT_W-1:0] evt_v;
    logic [STAT_W-1:0] clr_v;
    logic [STAT_W-1:0] flag_q;
    logic              rx_thr_q;
    logic              tx_thr_q;

    assign busy = mst_active | slv_active;

    always_comb begin
        evt_s.rx_under = rx_under_ev;
        evt_s.rx_over  = rx_over_ev;
        evt_s.tx_over  = tx_over_ev;
        evt_s.rd_req   = rd_req_ev;
        evt_s.rx_done  = rx_done_ev;
        evt_s.bus_act  = bus_act_ev;
        evt_s.stop     = stop_ev;
        evt_s.start    = start_ev;
        evt_s.gcall    = gcall_ev;
        clr_s.stb      = clr_stb;
        clr_s.mask     = clr_mask;
    end

    assign evt_v = evt_vector(evt_s);
    assign clr_v = clr_vector(clr_s);

    i2c_irq_evbank u_evbank (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .fsm_busy (busy),
        .evt      (evt_v),
        .clr      (clr_v),
        .flag_q   (flag_q)
    );

    i2c_irq_levels #(.LW(LW)) u_levels (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .fsm_busy (busy),
        .rx_lvl   (rx_level),
        .rx_thr   (rx_thresh),
        .tx_lvl   (tx_level),
        .tx_thr   (tx_thresh),
        .rx_thr_q (rx_thr_q),
        .tx_thr_q (tx_thr_q)
    );

    i2c_irq_abort u_abort (
        .clk        (clk),
        .rst        (rst),
        .ab_evt     (abort_ev),
        .sbyte_cond (sbyte_norst_cond),
        .clr_all    (clr_v[ST_TX_ABORT]),
        .cause_q    (abort_cause)
    );

    always_comb begin
        raw_stat              = flag_q;
        raw_stat[ST_RX_THR]   = rx_thr_q;
        raw_stat[ST_TX_THR]   = tx_thr_q;
        raw_stat[ST_TX_ABORT] = |abort_cause;
    end

    assign masked_stat = raw_stat & irq_en;
    assign irq         = |masked_stat;

    // R1: the abort status bit tracks the cause register
    a_r1_abort_bit: assert property (@(posedge clk) disable iff (rst)
        raw_stat[ST_TX_ABORT] == (abort_cause != '0));

endmodule

// File: tb/test_i2c_irq_status.sv
module test_i2c_irq_status;
    localparam int LW = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0, mst_active = 1'b0, slv_active = 1'b0;
    logic        rx_under_ev = 0, rx_over_ev = 0, tx_over_ev = 0, rd_req_ev = 0;
    logic        rx_done_ev = 0, bus_act_ev = 0, stop_ev = 0, start_ev = 0, gcall_ev = 0;
    logic [15:0] abort_ev = '0;
    logic        sbyte_norst_cond = 1'b0;
    logic [LW-1:0] rx_level = 0, rx_thresh = 8, tx_level = 5, tx_thresh = 2;
    logic        clr_stb = 1'b0;
    logic [11:0] clr_mask = '0, irq_en = '0;
    logic [11:0] raw_stat, masked_stat;
    logic        irq, busy;
    logic [15:0] abort_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    i2c_irq_status i_i2c_irq_status (
        .clk(clk), .rst(rst), .enable(enable), .mst_active(mst_active), .slv_active(slv_active),
        .rx_under_ev(rx_under_ev), .rx_over_ev(rx_over_ev), .tx_over_ev(tx_over_ev),
        .rd_req_ev(rd_req_ev), .rx_done_ev(rx_done_ev), .bus_act_ev(bus_act_ev),
        .stop_ev(stop_ev), .start_ev(start_ev), .gcall_ev(gcall_ev), .abort_ev(abort_ev),
        .sbyte_norst_cond(sbyte_norst_cond), .rx_level(rx_level), .rx_thresh(rx_thresh),
        .tx_level(tx_level), .tx_thresh(tx_thresh), .clr_stb(clr_stb), .clr_mask(clr_mask),
        .irq_en(irq_en), .raw_stat(raw_stat), .masked_stat(masked_stat), .irq(irq),
        .abort_cause(abort_cause), .busy(busy)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ev(int idx, logic v);
        case (idx)
            0:  rx_under_ev = v;
            1:  rx_over_ev  = v;
            3:  tx_over_ev  = v;
            5:  rd_req_ev   = v;
            7:  rx_done_ev  = v;
            8:  bus_act_ev  = v;
            9:  stop_ev     = v;
            10: start_ev    = v;
            11: gcall_ev    = v;
            default: ;
        endcase
    endtask

    task automatic pulse(int idx);
        set_ev(idx, 1'b1);
        tick();
        set_ev(idx, 1'b0);
    endtask

    task automatic clear(logic [11:0] m);
        clr_stb = 1'b1;
        clr_mask = m;
        tick();
        clr_stb = 1'b0;
        clr_mask = '0;
    endtask

    task automatic t_reset();
        chk("R1 reset raw", 32'(raw_stat), 0);
        chk("R7 reset cause", 32'(abort_cause), 0);
        chk("R12 reset irq", 32'(irq), 0);
        chk("R13 reset busy", 32'(busy), 0);
    endtask

    task automatic t_r1_positions();
        int idx_list[9] = '{0, 1, 3, 5, 7, 8, 9, 10, 11};
        enable = 1'b1;
        tick();
        foreach (idx_list[k]) begin
            pulse(idx_list[k]);
            chk($sformatf("R1 bit %0d", idx_list[k]), 32'(raw_stat), 32'(1) << idx_list[k]);
            clear(12'hFFF);
        end
        abort_ev = 16'h0001;
        tick();
        abort_ev = '0;
        chk("R1 abort bit 6", 32'(raw_stat), 32'h040);
        clear(12'hFFF);
        chk("R1 all clear", 32'(raw_stat), 0);
    endtask

    task automatic t_r2_rx_level();
        enable = 1'b1; rx_thresh = 4; rx_level = 3;
        tick(); chk("R2 below", 32'(raw_stat[2]), 0);
        rx_level = 4;
        tick(); chk("R2 equal", 32'(raw_stat[2]), 1);
        rx_level = 9;
        tick(); chk("R2 above", 32'(raw_stat[2]), 1);
        rx_level = 3;
        tick(); chk("R2 drop", 32'(raw_stat[2]), 0);
        rx_level = 5; enable = 1'b0;
        tick(); chk("R2 disabled", 32'(raw_stat[2]), 0);
        rx_level = 0; rx_thresh = 8; enable = 1'b1;
        tick();
    endtask

    task automatic t_r3_tx_level();
        enable = 1'b1; tx_thresh = 2; tx_level = 2;
        tick(); chk("R3 equal", 32'(raw_stat[4]), 1);
        tx_level = 3;
        tick(); chk("R3 above", 32'(raw_stat[4]), 0);
        enable = 1'b0; tx_level = 9; mst_active = 1'b1;
        tick(); chk("R3 disabled master busy", 32'(raw_stat[4]), 1);
        chk("R13 busy master", 32'(busy), 1);
        mst_active = 1'b0; slv_active = 1'b1;
        tick(); chk("R3 disabled slave busy", 32'(raw_stat[4]), 1);
        chk("R13 busy slave", 32'(busy), 1);
        slv_active = 1'b0;
        tick(); chk("R3 disabled idle", 32'(raw_stat[4]), 0);
        chk("R13 idle", 32'(busy), 0);
        tx_level = 5; enable = 1'b1;
        tick();
    endtask

    task automatic t_r4_clear_mask();
        pulse(5);
        pulse(7);
        clear(12'h080);
        chk("R4 cleared bit 7", 32'(raw_stat[7]), 0);
        chk("R4 untouched bit 5", 32'(raw_stat[5]), 1);
        repeat (3) tick();
        chk("R4 held bit 5", 32'(raw_stat[5]), 1);
        clear(12'h020);
        chk("R4 cleared bit 5", 32'(raw_stat[5]), 0);
    endtask

    task automatic t_r5_idle_clear();
        enable = 1'b1;
        pulse(1);
        pulse(3);
        enable = 1'b0; mst_active = 1'b1;
        repeat (3) tick();
        chk("R5 keep rx over while busy", 32'(raw_stat[1]), 1);
        chk("R5 keep tx over while busy", 32'(raw_stat[3]), 1);
        mst_active = 1'b0;
        tick();
        chk("R5 idle clears rx over", 32'(raw_stat[1]), 0);
        chk("R5 idle clears tx over", 32'(raw_stat[3]), 0);
        enable = 1'b1;
        tick();
    endtask

    task automatic t_r6_activity();
        enable = 1'b1;
        pulse(8);
        enable = 1'b0;
        repeat (4) tick();
        chk("R6 activity held after idle", 32'(raw_stat[8]), 1);
        clear(12'hEFF);
        chk("R6 other mask ignored", 32'(raw_stat[8]), 1);
        clear(12'h100);
        chk("R6 explicit clear", 32'(raw_stat[8]), 0);
        enable = 1'b1;
        tick();
    endtask

    task automatic t_r7_abort_clear();
        abort_ev = 16'h0009;
        tick();
        abort_ev = '0;
        chk("R7 causes set", 32'(abort_cause), 32'h0009);
        clear(12'h0BF);
        chk("R7 clear without bit 6", 32'(abort_cause), 32'h0009);
        chk("R1 abort bit on", 32'(raw_stat[6]), 1);
        clear(12'h040);
        chk("R7 clear with bit 6", 32'(abort_cause), 0);
        chk("R1 abort bit off", 32'(raw_stat[6]), 0);
        abort_ev = 16'h8000;
        tick();
        abort_ev = '0;
        clear(12'hFFF);
        chk("R7 clear all", 32'(abort_cause), 0);
    endtask

    task automatic t_r8_slave_arb();
        abort_ev = 16'h4000;
        tick();
        abort_ev = '0;
        chk("R8 bits 12 and 14", 32'(abort_cause), 32'h5000);
        clear(12'h040);
    endtask

    task automatic t_r9_rearm();
        sbyte_norst_cond = 1'b1;
        abort_ev = 16'h0200;
        tick();
        abort_ev = '0;
        chk("R9 set", 32'(abort_cause), 32'h0200);
        clear(12'h040);
        chk("R9 dropped one cycle", 32'(abort_cause), 0);
        tick();
        chk("R9 returned", 32'(abort_cause), 32'h0200);
        sbyte_norst_cond = 1'b0;
        clear(12'h040);
        chk("R9 cleared, condition gone", 32'(abort_cause), 0);
        tick();
        chk("R9 stays clear", 32'(abort_cause), 0);
    endtask

    task automatic t_r10_gcall();
        enable = 1'b1;
        pulse(11);
        chk("R10 gcall set", 32'(raw_stat[11]), 1);
        enable = 1'b0; mst_active = 1'b1;
        tick();
        chk("R10 disable clears", 32'(raw_stat[11]), 0);
        mst_active = 1'b0; enable = 1'b1;
        pulse(11);
        clear(12'h800);
        chk("R10 explicit clear", 32'(raw_stat[11]), 0);
    endtask

    task automatic t_r11_event_wins();
        stop_ev = 1'b1; clr_stb = 1'b1; clr_mask = 12'h200;
        tick();
        stop_ev = 1'b0; clr_stb = 1'b0; clr_mask = '0;
        chk("R11 event beats clear", 32'(raw_stat[9]), 1);
        clear(12'h200);
        chk("R11 later clear", 32'(raw_stat[9]), 0);
    endtask

    task automatic t_r12_mask();
        enable = 1'b1;
        pulse(0);
        pulse(8);
        irq_en = '0; #1;
        chk("R12 masked none", 32'(masked_stat), 0);
        chk("R12 irq off", 32'(irq), 0);
        irq_en = 12'h100; #1;
        chk("R12 masked activity", 32'(masked_stat), 32'h100);
        chk("R12 irq on", 32'(irq), 1);
        irq_en = 12'h002; #1;
        chk("R12 irq off other enable", 32'(irq), 0);
        irq_en = '0;
        clear(12'hFFF);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_r1_positions();
        t_r2_rx_level();
        t_r3_tx_level();
        t_r4_clear_mask();
        t_r5_idle_clear();
        t_r6_activity();
        t_r7_abort_clear();
        t_r8_slave_arb();
        t_r9_rearm();
        t_r10_gcall();
        t_r11_event_wins();
        t_r12_mask();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule